// File: doc/BRIEF.md
# Host-to-DMA Request FIFO Bridge

This block sits between a host CPU bus and a DMA engine owned by another processor. The host writes 16-bit words into a short queue, either as one whole word or as two byte-lane writes. The DMA side removes words from the head of the queue in the order they arrived. Two things change on every accepted push: a transfer-length down-counter, and the enable bit that stops further pushes once the counter reaches zero. Neither waits for the consumer to be active.

For every fourth word in the queue, a one-cycle request strobe goes to the DMA controller. That lets the consumer move data in bursts of four. A push into a full queue is dropped. A sticky overflow flag records the drop, and clearing the enable bit also clears that flag.

The host selects a register with a 3-bit code on `host_sel` and qualifies the write with `host_we`. Pops come from the DMA side on `pop_req`. Every output is registered.

Top module: `dreq_fifo_bridge`

## Requirements
- R1: A push (host write with `host_sel` 3 or 4) while `xfer_enable` is 0 changes no output other than what R8 says about the byte latch.
- R2: The queue holds 8 words of 16 bits. `fifo_level` counts the stored words. `fifo_full` is 1 exactly when 8 words are held.
- R3: Each accepted push decrements `xfer_len` by one, wrapping modulo 2^16.
- R4: When an accepted push brings `xfer_len` to zero, `xfer_enable` clears in the same update, whether or not anything is popping.
- R5: `dma_req` is high for one cycle, the cycle after an accepted push that leaves `fifo_level` at a non-zero multiple of 4.
- R6: A write with `host_sel` 0 sets `xfer_enable` to `host_wdata[0]`. If that bit is 0, the write also clears `fifo_level`, `fifo_full` and `overflow`.
- R7: A write with `host_sel` 1 loads `xfer_len` from `host_wdata`, with bits 1:0 forced to zero.
- R8: `host_sel` 2 latches `host_wdata[7:0]` as the high byte. `host_sel` 3 pushes {latched byte, `host_wdata[7:0]`} and clears the latch, whether or not the push is accepted. `host_sel` 4 pushes all of `host_wdata`.
- R9: A push while `xfer_enable` is 1 and 8 words are already held is dropped: the level, length, enable and contents are unchanged. The same push sets `overflow`.
- R10: A pop on a non-empty queue shows the oldest word on `pop_data` one cycle later, decrements `fifo_level` and clears `fifo_full`.
- R11: A pop on an empty queue leaves `pop_data` at its previous value and `fifo_level` at 0.
- R12: A push and a pop in the same cycle on a queue that is neither empty nor full leave the level unchanged and keep the word order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_we | input | 1 | Host write strobe |
| host_sel | input | 3 | Register select: 0 control, 1 length, 2 high byte, 3 low byte and push, 4 word push |
| host_wdata | input | 16 | Host write data |
| pop_req | input | 1 | DMA side pop request |
| pop_data | output | 16 | Word removed by the last effective pop |
| fifo_level | output | 4 | Number of stored words |
| fifo_full | output | 1 | Queue holds 8 words |
| xfer_enable | output | 1 | Host transfer enable |
| xfer_len | output | 16 | Remaining transfer length |
| dma_req | output | 1 | Burst request strobe to the DMA controller |
| overflow | output | 1 | Sticky flag for a dropped push |

## Verification
Every result of this block is due exactly one clock edge after the cycle that carries its stimulus. This covers the level, full flag, length, enable, request strobe, overflow flag and popped word, because all of them are registers updated directly from that cycle's inputs. The bench drives each stimulus on a falling edge and lets one rising edge pass. It then compares every output against its own model at the next falling edge, so each check lands in the single cycle where the result must appear. The request strobe is also compared on the cycle after that, which confirms it lasts a single cycle.

// File: rtl/dreq_pkg.sv
package dreq_pkg;
  typedef enum logic [2:0] {
    SEL_CTRL = 3'd0,
    SEL_LEN  = 3'd1,
    SEL_HI   = 3'd2,
    SEL_LO   = 3'd3,
    SEL_WORD = 3'd4
  } host_sel_e;
endpackage

// File: rtl/dreq_word_asm.sv
module dreq_word_asm
  import dreq_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [2:0]    sel,
  input  logic [DW-1:0] wdata,
  output logic          push_try,
  output logic [DW-1:0] push_word
);
  localparam int HB = DW / 2;

  logic [HB-1:0] hi_q;

  // R8: high byte is staged, low byte completes the word and clears the stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   hi_q <= '0;
    else if (we && sel == SEL_HI) hi_q <= wdata[HB-1:0];
    else if (we && sel == SEL_LO) hi_q <= '0;
  end

  assign push_try  = we && (sel == SEL_LO || sel == SEL_WORD);
  assign push_word = (sel == SEL_LO) ? {hi_q, wdata[HB-1:0]} : wdata;
endmodule

// File: rtl/dreq_store.sv
module dreq_store #(
  parameter int DW    = 16,
  parameter int DEPTH = 8,
  parameter int CW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [CW-1:0] level,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] mem [DEPTH];
  logic [CW-1:0] widx;

  // a pop shifts the queue down first, so the new word lands one slot lower
  assign widx = level - (rd_en ? CW'(1) : CW'(0));

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [DW-1:0] shift_in;
    if (i < DEPTH - 1) begin : g_mid
      assign shift_in = mem[i+1];
    end else begin : g_top
      assign shift_in = mem[i];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         mem[i] <= '0;
      else if (wr_en && widx == CW'(i))   mem[i] <= wr_data;
      else if (rd_en)                     mem[i] <= shift_in;
    end
  end

  // R10/R11: output word changes only on an effective pop
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= mem[0];
  end
endmodule

// File: rtl/dreq_ctl.sv
module dreq_ctl #(
  parameter int DEPTH     = 8,
  parameter int CW        = 4,
  parameter int LW        = 16,
  parameter int REQ_GROUP = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_wr,
  input  logic          ctl_bit,
  input  logic          len_wr,
  input  logic [LW-1:0] len_data,
  input  logic          push_try,
  input  logic          pop_req,
  output logic          push_ok,
  output logic          pop_ok,
  output logic          drop_evt,
  output logic [CW-1:0] level,
  output logic          full,
  output logic          enable,
  output logic [LW-1:0] len,
  output logic          req,
  output logic          ovf
);
  function automatic logic [LW-1:0] len_mask(input logic [LW-1:0] d);
    return {d[LW-1:2], 2'b00};
  endfunction

  function automatic logic group_hit(input logic [CW-1:0] lvl);
    return (lvl != '0) && ((int'(lvl) % REQ_GROUP) == 0);
  endfunction

  logic          clr;
  logic          at_depth;
  logic [CW-1:0] level_nx;
  logic [LW-1:0] len_dec;

  assign clr      = ctl_wr && !ctl_bit;
  assign at_depth = (level == CW'(DEPTH));
  assign push_ok  = push_try && enable && !at_depth;
  assign drop_evt = push_try && enable && at_depth;
  assign pop_ok   = pop_req && (level != '0) && !clr;
  assign level_nx = level + (push_ok ? CW'(1) : CW'(0)) - (pop_ok ? CW'(1) : CW'(0));
  assign len_dec  = len - LW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level  <= '0;
      full   <= 1'b0;
      enable <= 1'b0;
      req    <= 1'b0;
      ovf    <= 1'b0;
    end else if (clr) begin
      level  <= '0;
      full   <= 1'b0;
      enable <= 1'b0;
      req    <= 1'b0;
      ovf    <= 1'b0;
    end else begin
      level <= level_nx;
      full  <= (level_nx == CW'(DEPTH));
      req   <= push_ok && group_hit(level_nx);
      ovf   <= ovf || drop_evt;
      if (ctl_wr)                           enable <= 1'b1;
      else if (push_ok && len_dec == '0)    enable <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       len <= '0;
    else if (len_wr)  len <= len_mask(len_data);
    else if (push_ok) len <= len_dec;
  end
endmodule

// File: rtl/dreq_fifo_bridge.sv
module dreq_fifo_bridge
  import dreq_pkg::*;
#(
  parameter int DW        = 16,
  parameter int DEPTH     = 8,
  parameter int REQ_GROUP = 4,
  parameter int CW        = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_we,
  input  logic [2:0]    host_sel,
  input  logic [DW-1:0] host_wdata,
  input  logic          pop_req,
  output logic [DW-1:0] pop_data,
  output logic [CW-1:0] fifo_level,
  output logic          fifo_full,
  output logic          xfer_enable,
  output logic [DW-1:0] xfer_len,
  output logic          dma_req,
  output logic          overflow
);
  logic          push_try;
  logic          push_ok;
  logic          pop_ok;
  logic          drop_evt;
  logic [DW-1:0] push_word;
  logic          ctl_wr;
  logic          len_wr;

  assign ctl_wr = host_we && host_sel == SEL_CTRL;
  assign len_wr = host_we && host_sel == SEL_LEN;

  dreq_word_asm #(.DW(DW)) u_asm (
    .clk(clk), .rst_n(rst_n), .we(host_we), .sel(host_sel),
    .wdata(host_wdata), .push_try(push_try), .push_word(push_word)
  );

  dreq_ctl #(.DEPTH(DEPTH), .CW(CW), .LW(DW), .REQ_GROUP(REQ_GROUP)) u_ctl (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_bit(host_wdata[0]),
    .len_wr(len_wr), .len_data(host_wdata), .push_try(push_try),
    .pop_req(pop_req), .push_ok(push_ok), .pop_ok(pop_ok),
    .drop_evt(drop_evt), .level(fifo_level), .full(fifo_full),
    .enable(xfer_enable), .len(xfer_len), .req(dma_req), .ovf(overflow)
  );

  dreq_store #(.DW(DW), .DEPTH(DEPTH), .CW(CW)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(push_ok), .wr_data(push_word),
    .rd_en(pop_ok), .level(fifo_level), .rd_data(pop_data)
  );
endmodule

// File: rtl/dreq_fifo_bridge_chk.sv
module dreq_fifo_bridge_chk #(
  parameter int DW        = 16,
  parameter int DEPTH     = 8,
  parameter int REQ_GROUP = 4,
  parameter int CW        = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          host_we,
  input logic [2:0]    host_sel,
  input logic [DW-1:0] host_wdata,
  input logic          pop_req,
  input logic [CW-1:0] fifo_level,
  input logic          fifo_full,
  input logic          xfer_enable,
  input logic [DW-1:0] xfer_len,
  input logic          dma_req,
  input logic          overflow,
  input logic          push_try,
  input logic          push_ok,
  input logic          drop_evt
);
  a_r1_off_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    push_try && !xfer_enable && !pop_req |=> fifo_level == $past(fifo_level));

  a_r2_full_matches_level: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full == (fifo_level == CW'(DEPTH)));

  a_r3_len_step: assert property (@(posedge clk) disable iff (!rst_n)
    push_ok |=> xfer_len == $past(xfer_len) - DW'(1));

  a_r4_auto_off: assert property (@(posedge clk) disable iff (!rst_n)
    push_ok && xfer_len == DW'(1) |=> !xfer_enable);

  a_r5_req_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> fifo_level != '0 && (int'(fifo_level) % REQ_GROUP) == 0);

  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    host_we && host_sel == 3'd0 && !host_wdata[0] |=> fifo_level == '0 && !fifo_full && !overflow);

  a_r7_len_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_len[1:0] == 2'b00 || !$stable(xfer_len) || push_ok || !$past(host_we && host_sel == 3'd1));

  a_r9_drop_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt && !pop_req |=> fifo_level == CW'(DEPTH) && $stable(xfer_len) && overflow);
endmodule

bind dreq_fifo_bridge dreq_fifo_bridge_chk #(
  .DW(DW), .DEPTH(DEPTH), .REQ_GROUP(REQ_GROUP), .CW(CW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_sel(host_sel),
  .host_wdata(host_wdata), .pop_req(pop_req), .fifo_level(fifo_level),
  .fifo_full(fifo_full), .xfer_enable(xfer_enable), .xfer_len(xfer_len),
  .dma_req(dma_req), .overflow(overflow), .push_try(push_try),
  .push_ok(push_ok), .drop_evt(drop_evt)
);

// File: tb/dreq_fifo_bridge_bench.sv
module dreq_fifo_bridge_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_we = 1'b0;
  logic [2:0]  host_sel = 3'd0;
  logic [15:0] host_wdata = 16'd0;
  logic        pop_req = 1'b0;
  logic [15:0] pop_data;
  logic [3:0]  fifo_level;
  logic        fifo_full;
  logic        xfer_enable;
  logic [15:0] xfer_len;
  logic        dma_req;
  logic        overflow;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic [15:0] m_q [8];
  int          m_cnt = 0;
  logic        m_en = 0, m_req = 0, m_ovf = 0;
  logic [15:0] m_len = 0, m_pop = 0;
  logic [7:0]  m_hi = 0;

  always #4 clk = ~clk;

  dreq_fifo_bridge u_dreq_fifo_bridge (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_sel(host_sel),
    .host_wdata(host_wdata), .pop_req(pop_req), .pop_data(pop_data),
    .fifo_level(fifo_level), .fifo_full(fifo_full), .xfer_enable(xfer_enable),
    .xfer_len(xfer_len), .dma_req(dma_req), .overflow(overflow)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    chk({tag, " R2 level"}, 16'(fifo_level), 16'(m_cnt));
    chk({tag, " R2 full"}, 16'(fifo_full), 16'(m_cnt == 8));
    chk({tag, " R4 enable"}, 16'(xfer_enable), 16'(m_en));
    chk({tag, " R3 len"}, xfer_len, m_len);
    chk({tag, " R5 req"}, 16'(dma_req), 16'(m_req));
    chk({tag, " R9 ovf"}, 16'(overflow), 16'(m_ovf));
    chk({tag, " R10 pop_data"}, pop_data, m_pop);
  endtask

  // bench model of one cycle, written from the requirements
  task automatic model(input logic we, input logic [2:0] sel, input logic [15:0] d, input logic pop);
    logic clr, try, acc, pok;
    logic [15:0] word;
    int c0;
    c0   = m_cnt;
    clr  = we && sel == 3'd0 && !d[0];
    try  = we && (sel == 3'd3 || sel == 3'd4);
    word = (sel == 3'd3) ? {m_hi, d[7:0]} : d;
    acc  = try && m_en && c0 < 8;
    pok  = pop && c0 > 0 && !clr;
    m_req = 0;
    if (try && m_en && c0 == 8) m_ovf = 1;
    if (pok) begin
      m_pop = m_q[0];
      for (int i = 0; i < 7; i++) m_q[i] = m_q[i+1];
      m_cnt--;
    end
    if (acc) begin
      m_q[m_cnt] = word;
      m_cnt++;
      m_len = m_len - 16'd1;
      if (m_len == 0) m_en = 0;
      m_req = (m_cnt % 4) == 0;
    end
    if (we && sel == 3'd2) m_hi = d[7:0];
    if (we && sel == 3'd3) m_hi = 8'd0;
    if (we && sel == 3'd1) m_len = d & 16'hFFFC;
    if (we && sel == 3'd0) begin
      if (d[0]) m_en = 1;
      else begin m_en = 0; m_cnt = 0; m_ovf = 0; m_req = 0; end
    end
  endtask

  task automatic step(input string tag, input logic we, input logic [2:0] sel,
                      input logic [15:0] d, input logic pop);
    host_we = we; host_sel = sel; host_wdata = d; pop_req = pop;
    @(negedge clk);
    model(we, sel, d, pop);
    host_we = 0; pop_req = 0;
    compare_all(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] rv;
    rv = 16'($urandom(32'h5eed_0011));
    for (int i = 0; i < 8; i++) m_q[i] = 0;
    repeat (3) @(negedge clk);
    compare_all("reset");
    rst_n = 1;
    @(negedge clk);
    // R1: push while disabled is ignored
    step("R1 word", 1, 3'd4, 16'h1111, 0);
    chk("R1 level stays 0", 16'(fifo_level), 16'd0);
    // R7: low bits of length forced to zero
    step("R7 len", 1, 3'd1, 16'h0013, 0);
    chk("R7 len masked", xfer_len, 16'h0010);
    step("R6 enable", 1, 3'd0, 16'h0001, 0);
    // R8: byte split
    step("R8 hi", 1, 3'd2, 16'h77AB, 0);
    step("R8 lo", 1, 3'd3, 16'h88CD, 0);
    step("R8 lo alone", 1, 3'd3, 16'h0012, 0);
    step("R8 word", 1, 3'd4, 16'hBEEF, 0);
    step("R5 fourth", 1, 3'd4, 16'h0004, 0);
    chk("R5 req on fourth", 16'(dma_req), 16'd1);
    step("R5 idle", 0, 3'd0, 16'h0, 0);
    chk("R5 single cycle", 16'(dma_req), 16'd0);
    for (int i = 5; i <= 8; i++) step("R2 fill", 1, 3'd4, 16'(16'h0100 + i), 0);
    chk("R2 full at 8", 16'(fifo_full), 16'd1);
    step("R9 drop", 1, 3'd4, 16'hDEAD, 0);
    chk("R9 overflow set", 16'(overflow), 16'd1);
    step("R10 pop", 0, 3'd0, 16'h0, 1);
    chk("R10 first word", pop_data, 16'hABCD);
    step("R12 push+pop", 1, 3'd4, 16'h0CAB, 1);
    chk("R12 level kept", 16'(fifo_level), 16'd7);
    for (int i = 0; i < 8; i++) step("R10 drain", 0, 3'd0, 16'h0, 1);
    chk("R11 held data", pop_data, 16'h0CAB);
    // R4: length runs out
    step("R4 len", 1, 3'd1, 16'h0004, 0);
    for (int i = 0; i < 4; i++) step("R4 push", 1, 3'd4, 16'(i), 0);
    chk("R4 enable auto off", 16'(xfer_enable), 16'd0);
    step("R1 after off", 1, 3'd4, 16'h5555, 0);
    step("R6 clear", 1, 3'd0, 16'h0000, 0);
    chk("R6 level cleared", 16'(fifo_level), 16'd0);
    // random phase
    for (int n = 0; n < 4000; n++) begin
      int r;
      logic [2:0] s;
      logic [15:0] d;
      r = int'($urandom % 100);
      d = 16'($urandom);
      if (r < 3)       s = 3'd0;
      else if (r < 10) begin s = 3'd0; d[0] = 1'b1; end
      else if (r < 14) begin s = 3'd1; d = 16'($urandom % 48); end
      else if (r < 30) s = 3'd2;
      else if (r < 55) s = 3'd3;
      else if (r < 80) s = 3'd4;
      else             s = 3'd5;
      step("rand", r < 90, s, d, ($urandom % 3) == 0);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule